// File: doc/BRIEF.md
# Erase Suspend and Status Controller

This block sits next to a flash erase engine. It watches the command write port for the single-cycle suspend, resume and read/reset codes. It tells the engine when to pause an erase, ends a running erase-start timeout when the suspend arrives inside that window, and permits a program operation to start while the erase is held.

On every read it decides whether the data bus carries array data or status. When status is selected, it supplies four status bits:
- a done bit, which is low while the engine is busy;
- a timer bit, which is low while the erase-start timeout runs;
- two toggle bits. Each changes state after a qualifying read. The rules for each toggle bit depend on the phase (erasing, suspended, or programming while suspended) and on whether the addressed block belongs to the erase set.

The suspend takes effect after a parameterised number of cycles. During those cycles the engine is still running and the toggle bits still change.

Top module: `esr_status_ctrl`

## Requirements
- R1: After reset `susp_req`, `tmo_stop` and `erase_abort` are 0. With `erase_busy` and `pgm_busy` both low, `stat_sel` is 0 on every read and `st_dq7` is 1. `st_dq7` is 0 whenever `erase_busy` or `pgm_busy` is high.
- R2: A write of 0xB0 is a suspend. It is accepted at any block only while not suspended and `erase_busy` is high. On acceptance `susp_req` goes to 1 one cycle after the write. A suspend written when no erase is running has no effect.
- R3: If `erase_tmo` is high when a suspend is accepted, `tmo_stop` pulses for exactly the one cycle after the write. If `erase_tmo` is low, `tmo_stop` stays 0. When not suspended, `st_dq3` equals the inverse of `erase_tmo`. From the suspend onward, `st_dq3` is 1.
- R4: While an erase runs and is not suspended, every read has `stat_sel`=1. `st_dq6` inverts after each such read. `st_dq2` inverts only after reads whose block has its bit set in `erase_mask`, where bit i stands for block i.
- R5: For the `SUSP_LAT` cycles that follow an accepted suspend, reads behave as in R4. From then on the block is in the suspended state.
- R6: While suspended with no program running, a read of a block in `erase_mask` gives `stat_sel`=1 and `st_dq6`=1, and `st_dq2` inverts after each such read. A read of any other block gives `stat_sel`=0.
- R7: While suspended, writes other than 0x30 and 0xF0 are ignored. This includes a repeated 0xB0, and `susp_req` stays 1.
- R8: `pgm_go` follows `pgm_req` only in the suspended state, with `pgm_busy` low and `wr_blk` outside `erase_mask`. Otherwise `pgm_go` is 0.
- R9: While suspended with `pgm_busy` high, every read gives `stat_sel`=1, and both `st_dq2` and `st_dq6` invert after each read.
- R10: A write of 0x30 at any block, made while suspended with `pgm_busy` low, clears `susp_req` one cycle later. A write of 0x30 at any other time is ignored.
- R11: A write of 0xF0 made while suspended with `pgm_busy` low pulses `erase_abort` for the one following cycle and clears `susp_req`. A write of 0xF0 at any other time leaves `erase_abort` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_stb | input | 1 | Command write strobe, one cycle per write |
| wr_data | input | 8 | Command write data |
| wr_blk | input | BLK_W | Block index of the write or program target |
| pgm_req | input | 1 | Program request from the command decoder |
| rd_stb | input | 1 | Read strobe, one cycle per read |
| rd_blk | input | BLK_W | Block index of the read address |
| erase_busy | input | 1 | Engine holds an unfinished erase |
| erase_tmo | input | 1 | Erase-start timeout running |
| pgm_busy | input | 1 | Engine programming |
| erase_mask | input | NUM_BLK | Blocks in the erase set, bit i for block i |
| susp_req | output | 1 | Pause request to the erase engine |
| tmo_stop | output | 1 | One-cycle pulse that ends the erase-start timeout |
| erase_abort | output | 1 | One-cycle pulse that aborts the suspended erase |
| pgm_go | output | 1 | Permission to start a program while suspended |
| stat_sel | output | 1 | 1 selects status onto the read bus, 0 selects array data |
| st_dq2 | output | 1 | Toggle bit that tracks the erase set |
| st_dq3 | output | 1 | Timer status bit |
| st_dq6 | output | 1 | Toggle bit that tracks engine activity |
| st_dq7 | output | 1 | Done status bit |

## Verification
The assertions check on every cycle that:
- a suspend is entered only while an erase is busy;
- the suspended state is reached only through the latency window, and the window counter stays in range;
- the timeout stop and abort pulses occur only in their proper states;
- the activity toggle bit holds during a plain suspended read;
- the program permission appears only while suspended.

Only the bench scenarios can show the remaining behaviour:
- the exact length of the latency window;
- the sequence of toggle values across sweeps of blocks and phases;
- the routing between array data and status for each block;
- the rejection of commands written at the wrong time.

// File: rtl/esr_pkg.sv
package esr_pkg;
   localparam int CMD_W = 8;

   localparam logic [CMD_W-1:0] CMD_SUSPEND = 8'hB0;
   localparam logic [CMD_W-1:0] CMD_RESUME  = 8'h30;
   localparam logic [CMD_W-1:0] CMD_RESET   = 8'hF0;

   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_WAIT = 2'd1,
      ST_SUSP = 2'd2
   } esr_state_e;
endpackage

// File: rtl/esr_blk_lookup.sv
module esr_blk_lookup #(
   parameter int NUM_BLK = 8,
   parameter int BLK_W   = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
   input  logic [NUM_BLK-1:0] mask,
   input  logic [BLK_W-1:0]   idx,
   output logic               hit
);
   localparam bit POW2 = (NUM_BLK == (1 << BLK_W));

   generate
      if (NUM_BLK == 1) begin : g_single
         assign hit = mask[0];
      end else if (POW2) begin : g_direct
         assign hit = mask[idx];
      end else begin : g_decode
         always_comb begin
            hit = 1'b0;
            for (int i = 0; i < NUM_BLK; i++)
               if (idx == BLK_W'(i)) hit = hit | mask[i];
         end
      end
   endgenerate
endmodule

// File: rtl/esr_toggle.sv
module esr_toggle #(
   parameter bit INIT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flip,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= INIT;
      else if (flip) q <= ~q;
   end
endmodule

// File: rtl/esr_cmd_fsm.sv
module esr_cmd_fsm
   import esr_pkg::*;
#(
   parameter int SUSP_LAT = 4,
   parameter int CNT_W    = $clog2(SUSP_LAT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_stb,
   input  logic [CMD_W-1:0] wr_data,
   input  logic             erase_busy,
   input  logic             erase_tmo,
   input  logic             pgm_busy,
   output esr_state_e       state_q,
   output logic             tmo_stop,
   output logic             erase_abort
);
   logic [CNT_W-1:0] cnt_q;
   logic             take_susp, take_resume, take_reset;

   assign take_susp   = wr_stb && (wr_data == CMD_SUSPEND) && erase_busy && (state_q == ST_RUN);
   assign take_resume = wr_stb && (wr_data == CMD_RESUME)  && !pgm_busy  && (state_q == ST_SUSP);
   assign take_reset  = wr_stb && (wr_data == CMD_RESET)   && !pgm_busy  && (state_q == ST_SUSP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_RUN;
         cnt_q       <= '0;
         tmo_stop    <= 1'b0;
         erase_abort <= 1'b0;
      end else begin
         tmo_stop    <= take_susp && erase_tmo;
         erase_abort <= take_reset;
         unique case (state_q)
            ST_RUN: if (take_susp) begin
               state_q <= ST_WAIT;
               cnt_q   <= CNT_W'(SUSP_LAT - 1);
            end
            ST_WAIT: begin
               if (cnt_q == '0) state_q <= ST_SUSP;
               else             cnt_q   <= cnt_q - 1'b1;
            end
            ST_SUSP: if (take_resume || take_reset) state_q <= ST_RUN;
            default: state_q <= ST_RUN;
         endcase
      end
   end

   AST_SUSP_NEEDS_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT && $past(state_q) == ST_RUN) |-> $past(erase_busy)); // R2
   AST_SUSP_VIA_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SUSP && $past(state_q) != ST_SUSP) |-> $past(state_q) == ST_WAIT); // R5
   AST_WAIT_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT) |-> (cnt_q < CNT_W'(SUSP_LAT))); // R5
   AST_TMO_STOP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_stop |-> ($past(erase_tmo) && $past(state_q) == ST_RUN)); // R3
   AST_ABORT_FROM_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
      erase_abort |-> ($past(state_q) == ST_SUSP && state_q == ST_RUN)); // R11
endmodule

// File: rtl/esr_status_ctrl.sv
module esr_status_ctrl
   import esr_pkg::*;
#(
   parameter int NUM_BLK  = 8,
   parameter int SUSP_LAT = 4,
   parameter int BLK_W    = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_stb,
   input  logic [CMD_W-1:0]   wr_data,
   input  logic [BLK_W-1:0]   wr_blk,
   input  logic               pgm_req,
   input  logic               rd_stb,
   input  logic [BLK_W-1:0]   rd_blk,
   input  logic               erase_busy,
   input  logic               erase_tmo,
   input  logic               pgm_busy,
   input  logic [NUM_BLK-1:0] erase_mask,
   output logic               susp_req,
   output logic               tmo_stop,
   output logic               erase_abort,
   output logic               pgm_go,
   output logic               stat_sel,
   output logic               st_dq2,
   output logic               st_dq3,
   output logic               st_dq6,
   output logic               st_dq7
);
   generate
      if (SUSP_LAT < 1) begin : g_bad_lat
         $error("SUSP_LAT must be at least 1");
      end
      if (NUM_BLK < 1) begin : g_bad_blk
         $error("NUM_BLK must be at least 1");
      end
   endgenerate

   esr_state_e state;
   logic rd_hit, wr_hit, susp, spgm, susp_idle, erasing;
   logic flip2, flip6, t2, t6;

   esr_cmd_fsm #(.SUSP_LAT(SUSP_LAT)) u_fsm (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
      .erase_busy(erase_busy), .erase_tmo(erase_tmo), .pgm_busy(pgm_busy),
      .state_q(state), .tmo_stop(tmo_stop), .erase_abort(erase_abort));

   esr_blk_lookup #(.NUM_BLK(NUM_BLK), .BLK_W(BLK_W)) u_rd_lookup (
      .mask(erase_mask), .idx(rd_blk), .hit(rd_hit));
   esr_blk_lookup #(.NUM_BLK(NUM_BLK), .BLK_W(BLK_W)) u_wr_lookup (
      .mask(erase_mask), .idx(wr_blk), .hit(wr_hit));

   assign susp      = (state == ST_SUSP);
   assign spgm      = susp && pgm_busy;
   assign susp_idle = susp && !pgm_busy;
   assign erasing   = erase_busy && !susp;

   assign susp_req  = (state != ST_RUN);
   assign pgm_go    = pgm_req && susp_idle && !wr_hit;
   assign stat_sel  = erasing || spgm || (susp_idle && rd_hit);

   assign flip6 = rd_stb && (erasing || spgm);
   assign flip2 = rd_stb && (spgm || (erase_busy && rd_hit));

   esr_toggle #(.INIT(1'b0)) u_tog6 (.clk(clk), .rst_n(rst_n), .flip(flip6), .q(t6));
   esr_toggle #(.INIT(1'b0)) u_tog2 (.clk(clk), .rst_n(rst_n), .flip(flip2), .q(t2));

   assign st_dq6 = susp_idle ? 1'b1 : t6;
   assign st_dq2 = t2;
   assign st_dq3 = (state == ST_RUN) ? ~erase_tmo : 1'b1;
   assign st_dq7 = ~(erase_busy || pgm_busy);

   AST_DQ6_HOLD_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
      (susp_idle && rd_stb) |=> $stable(t6)); // R6
   AST_GRANT_IN_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
      pgm_go |-> (susp_req && !pgm_busy)); // R8
   AST_REQ_RISE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(susp_req) |-> $past(erase_busy && wr_stb)); // R2
endmodule

// File: tb/esr_status_ctrl_bench.sv
module esr_status_ctrl_bench;
   localparam int NB  = 4;
   localparam int LAT = 3;
   localparam int BW  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_stb = 0, pgm_req = 0, rd_stb = 0;
   logic [7:0] wr_data = 8'h00;
   logic [BW-1:0] wr_blk = '0, rd_blk = '0;
   logic erase_busy = 0, erase_tmo = 0, pgm_busy = 0;
   logic [NB-1:0] erase_mask = '0;
   logic susp_req, tmo_stop, erase_abort, pgm_go, stat_sel;
   logic st_dq2, st_dq3, st_dq6, st_dq7;

   int checks = 0, failures = 0;
   logic e2 = 0, e6 = 0;

   always #5 clk = ~clk;

   esr_status_ctrl #(.NUM_BLK(NB), .SUSP_LAT(LAT)) u_esr_status_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data), .wr_blk(wr_blk),
      .pgm_req(pgm_req), .rd_stb(rd_stb), .rd_blk(rd_blk), .erase_busy(erase_busy),
      .erase_tmo(erase_tmo), .pgm_busy(pgm_busy), .erase_mask(erase_mask),
      .susp_req(susp_req), .tmo_stop(tmo_stop), .erase_abort(erase_abort),
      .pgm_go(pgm_go), .stat_sel(stat_sel), .st_dq2(st_dq2), .st_dq3(st_dq3),
      .st_dq6(st_dq6), .st_dq7(st_dq7));

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(input logic [7:0] d, input logic [BW-1:0] b);
      wr_stb = 1; wr_data = d; wr_blk = b;
      @(negedge clk);
      wr_stb = 0;
   endtask

   // mode: 0 erasing, 1 suspended idle, 2 suspended program
   task automatic rd_chk(input string req, input logic [BW-1:0] b, input int mode);
      logic hit;
      hit = erase_mask[b];
      rd_stb = 1; rd_blk = b;
      #1;
      if (mode == 0) begin
         chk(req, stat_sel, 1'b1);
         chk(req, st_dq6, e6);
         chk(req, st_dq2, e2);
         e6 = ~e6;
         if (hit) e2 = ~e2;
      end else if (mode == 1) begin
         chk(req, stat_sel, hit);
         if (hit) begin
            chk(req, st_dq6, 1'b1);
            chk(req, st_dq2, e2);
            e2 = ~e2;
         end
      end else begin
         chk(req, stat_sel, 1'b1);
         chk(req, st_dq6, e6);
         chk(req, st_dq2, e2);
         chk(req, st_dq7, 1'b0);
         e6 = ~e6; e2 = ~e2;
      end
      @(negedge clk);
      rd_stb = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset and idle
      chk("R1", susp_req, 0); chk("R1", tmo_stop, 0); chk("R1", erase_abort, 0);
      for (int b = 0; b < NB; b++) begin
         rd_stb = 1; rd_blk = BW'(b); #1;
         chk("R1", stat_sel, 0); chk("R1", st_dq7, 1);
         @(negedge clk); rd_stb = 0;
      end
      // R2 suspend with no erase ignored; R10 resume ignored; R11 reset ignored
      wr(8'hB0, 2'd1); chk("R2", susp_req, 0);
      wr(8'h30, 2'd0); chk("R10", susp_req, 0);
      wr(8'hF0, 2'd0); chk("R11", erase_abort, 0);

      // R4 erase running with timeout, sweep blocks twice
      erase_mask = 4'b0101; erase_busy = 1; erase_tmo = 1;
      #1; chk("R1", st_dq7, 0); chk("R3", st_dq3, 0);
      for (int r = 0; r < 2; r++)
         for (int b = 0; b < NB; b++) rd_chk("R4", BW'(b), 0);
      wr(8'hF0, 2'd2); chk("R11", erase_abort, 0); chk("R11", susp_req, 0);

      // R2/R3 suspend during the timeout
      wr(8'hB0, 2'd3);
      chk("R2", susp_req, 1); chk("R3", tmo_stop, 1); chk("R3", st_dq3, 1);
      erase_tmo = 0;
      // R5 latency window: LAT reads still behave as erasing
      for (int k = 0; k < LAT; k++) begin
         if (k == 1) chk("R3", tmo_stop, 0);
         rd_chk("R5", BW'(k), 0);
      end
      // R6 suspended sweep
      for (int r = 0; r < 2; r++)
         for (int b = 0; b < NB; b++) rd_chk("R6", BW'(b), 1);
      // R7 stray commands ignored
      wr(8'hB0, 2'd0); chk("R7", susp_req, 1);
      wr(8'h55, 2'd1); chk("R7", susp_req, 1);
      rd_chk("R7", 2'd0, 1);
      // R8 program permission
      for (int b = 0; b < NB; b++) begin
         pgm_req = 1; wr_blk = BW'(b); #1;
         chk("R8", pgm_go, ~erase_mask[b]);
         @(negedge clk); pgm_req = 0;
      end
      // R9 program in suspend
      pgm_busy = 1;
      pgm_req = 1; wr_blk = 2'd1; #1; chk("R8", pgm_go, 0);
      @(negedge clk); pgm_req = 0;
      for (int b = 0; b < NB; b++) rd_chk("R9", BW'(b), 2);
      wr(8'h30, 2'd2); chk("R10", susp_req, 1);
      wr(8'hF0, 2'd2); chk("R11", erase_abort, 0);
      pgm_busy = 0;
      @(negedge clk);
      // R10 resume
      wr(8'h30, 2'd1); chk("R10", susp_req, 0);
      for (int b = 0; b < NB; b++) rd_chk("R10", BW'(b), 0);
      pgm_req = 1; wr_blk = 2'd1; #1; chk("R8", pgm_go, 0);
      @(negedge clk); pgm_req = 0;

      // second suspend without timeout, then abort
      wr(8'hB0, 2'd0); chk("R3", tmo_stop, 0); chk("R2", susp_req, 1);
      repeat (LAT) @(negedge clk);
      rd_chk("R6", 2'd2, 1);
      wr(8'hF0, 2'd3);
      chk("R11", erase_abort, 1); chk("R11", susp_req, 0);
      erase_busy = 0;
      @(negedge clk);
      chk("R11", erase_abort, 0);
      for (int b = 0; b < NB; b++) begin
         rd_stb = 1; rd_blk = BW'(b); #1;
         chk("R1", stat_sel, 0); chk("R1", st_dq7, 1);
         @(negedge clk); rd_stb = 0;
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule